// File: doc/BRIEF.md
# System Reset Control Register

This block is a single byte-wide control register on a simple I/O bus, decoded at port address 0xCF9. Software uses it in two ways. A write with bit 2 set asks the system to reset: the block raises a one-clock request pulse toward an external reset sequencer, and the stored byte is left as it was. Any other write to the port keeps only bit 1 and clears all other stored bits. Bit 1 records which kind of reset the sequencer should perform.

Reads of the port return the stored byte. Accesses to any other address do nothing. The read path is combinational from the stored byte, so a read and a write in the same cycle return the contents held before that write.

Top module: `sysreset_ctl`

## Requirements
- R1: After reset the stored byte is 0x00 and `rst_req` is low.
- R2: A write to address 0xCF9 whose data has bit 2 clear stores data bit 1 in bit 1. All other stored bits become 0.
- R3: A write to address 0xCF9 whose data has bit 2 set leaves the stored byte unchanged.
- R4: A write to address 0xCF9 with data bit 2 set drives `rst_req` high for exactly the one clock cycle after the write. Without another such write, `rst_req` is low in the cycle after that.
- R5: While `io_rd` is high and `io_addr` equals 0xCF9, `io_rdata` shows the stored byte in the same cycle.
- R6: A write to any address other than 0xCF9 does not change the stored byte and does not raise `rst_req`.
- R7: `io_rdata` is 0x00 whenever `io_rd` is low or `io_addr` is not 0xCF9.
- R8: A read and a write to 0xCF9 in the same cycle return the byte stored before that write. The write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per high cycle |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Some properties are checked on every cycle by the in-module assertions:
- stored bits other than the reset-type bit are never set;
- a triggering write leaves the store untouched;
- writes to other addresses change nothing;
- the request pulse is always caused by a write in the previous cycle and never lasts two cycles without a new trigger.

Other behaviour can only be shown by the bench scenarios:
- the exact value kept for every one of the 256 write bytes;
- readback through the port, including the same-cycle read/write ordering;
- the zero returned for neighbouring and bit-flipped addresses;
- clearing by a reset applied in the middle of the test.

// File: rtl/sysreset_ctl.sv
module sysreset_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
  parameter int TRIG_BIT = 2,
  parameter int TYPE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  output logic              rst_req
);

  localparam logic [DATA_W-1:0] TYPE_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << TYPE_BIT;

  logic              hit;
  logic              wr_hit;
  logic              trig;
  logic [DATA_W-1:0] ctl_q;

  assign hit    = (io_addr == PORT_ADDR);
  assign wr_hit = io_wr & hit;
  assign trig   = wr_hit & io_wdata[TRIG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= trig;
      if (wr_hit && !io_wdata[TRIG_BIT])
        ctl_q <= io_wdata & TYPE_MASK;
    end
  end

  assign io_rdata = (io_rd && hit) ? ctl_q : '0;

  // R2: only the reset-type bit can ever be held
  p_only_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~TYPE_MASK) == '0);

  // R3: a triggering write leaves the store alone
  p_trig_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && hit && io_wdata[TRIG_BIT]) |=> $stable(ctl_q));

  // R4: a request is always caused by a write one cycle earlier
  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(io_wr && hit));

  // R4: without a new trigger the pulse ends after one cycle
  p_pulse_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !(io_wr && hit && io_wdata[TRIG_BIT])) |=> !rst_req);

  // R6: writes elsewhere change nothing
  p_miss_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !hit) |=> ($stable(ctl_q) && !rst_req));

  // R7: read data can never carry bits other than the type bit
  p_rdata_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata & ~TYPE_MASK) == '0);

endmodule

// File: tb/sysreset_ctl_tb_top.sv
`timescale 1ns/1ps
module sysreset_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q = 8'h00;

  localparam logic [15:0] PORT = 16'hCF9;

  always #2.5 clk = ~clk;

  sysreset_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    chk(io_rdata == e, req, io_rdata, e);
    @(negedge clk);
    io_rd = 1'b0;
    #1;
    chk(io_rdata == 8'h00, "R7 idle", io_rdata, 0);
  endtask

  task automatic wr_chk(input logic [15:0] a, input logic [7:0] d);
    bit   is_hit = (a == PORT);
    bit   fire = is_hit && d[2];
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (is_hit && !d[2]) exp_q = d & 8'h02;
    chk(rst_req == fire, fire ? "R4 pulse" : (is_hit ? "R2 no req" : "R6 no req"), rst_req, fire);
    @(negedge clk);
    chk(rst_req == 1'b0, "R4 single cycle", rst_req, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rst_req == 1'b0, "R1 req in reset", rst_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rst_req == 1'b0, "R1 req after reset", rst_req, 0);
    rd_chk(PORT, 8'h00, "R1 reset value");

    // R2 R3 R4 R5: every write byte to the port
    for (int d = 0; d < 256; d++) begin
      wr_chk(PORT, 8'(d));
      rd_chk(PORT, exp_q, d[2] ? "R3 store kept" : "R2 stored value");
    end

    // R6 R7: miss addresses, store held at 0x02
    wr_chk(PORT, 8'h02);
    for (int b = 0; b < 16; b++) begin
      logic [15:0] a = PORT ^ (16'h1 << b);
      wr_chk(a, 8'h04);
      wr_chk(a, 8'h00);
      rd_chk(a, 8'h00, "R7 miss read");
      rd_chk(PORT, 8'h02, "R6 store after miss");
    end
    wr_chk(16'hCF8, 8'hFF);
    wr_chk(16'hCFA, 8'h00);
    rd_chk(16'hCF8, 8'h00, "R7 miss read CF8");
    rd_chk(PORT, 8'h02, "R6 store after neighbours");

    // R7: strobe low at the port
    @(negedge clk);
    io_addr = PORT; #1;
    chk(io_rdata == 8'h00, "R7 no strobe", io_rdata, 0);

    // R8: simultaneous read and write
    @(negedge clk);
    io_addr = PORT; io_wdata = 8'h00; io_wr = 1'b1; io_rd = 1'b1;
    #1;
    chk(io_rdata == 8'h02, "R8 old value", io_rdata, 8'h02);
    @(negedge clk);
    io_wr = 1'b0;
    #1;
    chk(io_rdata == 8'h00, "R8 new value", io_rdata, 0);
    io_rd = 1'b0;
    @(negedge clk);
    io_wdata = 8'h06; io_wr = 1'b1; io_rd = 1'b1; io_addr = PORT;
    #1;
    chk(io_rdata == 8'h00, "R8 old before trigger", io_rdata, 0);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    chk(rst_req == 1'b1, "R4 pulse with read", rst_req, 1);

    // R4: back-to-back triggers
    @(negedge clk);
    io_addr = PORT; io_wdata = 8'h04; io_wr = 1'b1;
    @(negedge clk);
    chk(rst_req == 1'b1, "R4 first of pair", rst_req, 1);
    @(negedge clk);
    io_wr = 1'b0;
    chk(rst_req == 1'b1, "R4 second of pair", rst_req, 1);
    @(negedge clk);
    chk(rst_req == 1'b0, "R4 pair ends", rst_req, 0);

    // R1: reset mid-run clears the store
    wr_chk(PORT, 8'h02);
    rd_chk(PORT, 8'h02, "R2 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_q = 8'h00;
    rd_chk(PORT, 8'h00, "R1 cleared by reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule